// File: doc/BRIEF.md
# Width-Matching Synchronous FIFO

This block is a single-clock FIFO whose write port and read port may differ in width. Each port is 36, 18 or 9 bits wide, and five pairings are allowed. Storage is a small array of 36-bit entries. When the write port is wide and the read port is narrow, each stored entry comes out over two or four reads. When the write port is narrow and the read port is wide, two or four writes are packed into one entry.

The width pairing and the order of the sub-words are set by configuration pins. These pins are sampled only while master reset is held. The narrow side uses lanes of the 36-bit entry. A 9-bit lane k is bits [9k+8:9k], for k = 0 to 3. An 18-bit lane k is bits [18k+17:18k], for k = 0 to 1. A narrow port carries its data in the low bits of its 36-bit data bus.

Reads are first-word-fall-through: while `empty` is low, `rd_data` already shows the next sub-word or word, and asserting `rd_en` moves past it.

Top module: `width_match_fifo`

## Requirements
- R1: While `mrst_n` is low, the pins {cfg_mix, cfg_dir, cfg_fine} select the widths as write/read: 000 gives 36/36, 100 gives 36/18, 101 gives 36/9, 110 gives 18/36 and 111 gives 9/36.
- R2: Any other value of {cfg_mix, cfg_dir, cfg_fine} behaves as 36/36.
- R3: The width pins and `cfg_msb_first` are captured only while `mrst_n` is low. Changing them after reset has no effect on the widths or on the sub-word order.
- R4: With `cfg_msb_first`=1, the most significant lane of an entry is the first sub-word read out (wide to narrow) or the first sub-word written in (narrow to wide).
- R5: With `cfg_msb_first`=0, the least significant lane is the first sub-word transferred.
- R6: When narrow writes are packed, an entry becomes readable only after all of its sub-words have been written. Until then `empty` stays high.
- R7: On a narrow read port, `empty` stays low while an entry is only partly read. It rises only after the last sub-word of the last entry has been read.
- R8: `full` is high exactly when DEPTH complete entries are stored. A write while `full` is high is ignored, and a read while `empty` is high is ignored.
- R9: On a narrow write port, only the low 18 or 9 bits of `wr_data` are stored. On a narrow read port, the bits of `rd_data` above the port width read as zero.
- R10: After master reset the FIFO holds nothing: `empty`=1 and `full`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Synchronous master reset, active low; configuration is sampled while it is low |
| cfg_mix | input | 1 | Selects mixed widths when high |
| cfg_dir | input | 1 | When mixed: 0 makes the read port narrow, 1 makes the write port narrow |
| cfg_fine | input | 1 | When mixed: the narrow port is 9 bits if 1, otherwise 18 bits |
| cfg_msb_first | input | 1 | Sub-word order: 1 transfers the most significant lane first |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write data; a narrow port uses the low bits |
| full | output | 1 | No room for another entry |
| rd_en | input | 1 | Read request; advances past the shown sub-word or word |
| rd_data | output | 36 | Current read sub-word or word, zero-extended when narrow |
| empty | output | 1 | No complete entry is available |

## Verification
A wrong lane index or sub-word counter shows up on `rd_data` at the very next read. On the packing side it shows up as a word with swapped lanes once the entry completes. An off-by-one in the sub-word counters makes `empty` change one sub-word early or late, and this is visible on the cycle after the read or write that should have changed it. A width or order captured at the wrong time shows up as wrong data on the first transfer after the configuration pins move. The bench keeps a model of the entry queue and the sub-word positions, and compares both flags and `rd_data` on every cycle.

// File: rtl/width_match_fifo.sv
`timescale 1ns/1ps
module width_match_fifo #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        mrst_n,
  input  logic        cfg_mix,
  input  logic        cfg_dir,
  input  logic        cfg_fine,
  input  logic        cfg_msb_first,
  input  logic        wr_en,
  input  logic [35:0] wr_data,
  output logic        full,
  input  logic        rd_en,
  output logic [35:0] rd_data,
  output logic        empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] W36 = 2'd0, W18 = 2'd1, W9 = 2'd2;

  logic [1:0]  wsel, rsel;
  logic        msb_first;
  logic [35:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic [1:0]  wsub, rsub, wlast, rlast, wpos, rpos;
  logic [5:0]  woff, roff;
  logic [35:0] stage, merged, head;
  logic        wr_ok, rd_ok, push, pop;

  // width and order are latched only during master reset (R1, R2, R3)
  always_ff @(posedge clk)
    if (!mrst_n) begin
      wsel <= W36;
      rsel <= W36;
      if (cfg_mix) begin
        if (cfg_dir) wsel <= cfg_fine ? W9 : W18;
        else         rsel <= cfg_fine ? W9 : W18;
      end
      msb_first <= cfg_msb_first;
    end

  assign wlast = (wsel == W9) ? 2'd3 : (wsel == W18) ? 2'd1 : 2'd0;
  assign rlast = (rsel == W9) ? 2'd3 : (rsel == W18) ? 2'd1 : 2'd0;
  assign wpos  = msb_first ? wlast - wsub : wsub;
  assign rpos  = msb_first ? rlast - rsub : rsub;
  assign woff  = (wsel == W18) ? (wpos[0] ? 6'd18 : 6'd0) : 6'(wpos) * 6'd9;
  assign roff  = (rsel == W18) ? (rpos[0] ? 6'd18 : 6'd0) : 6'(rpos) * 6'd9;

  assign full  = cnt == CW'(DEPTH);
  assign empty = cnt == '0;
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;
  assign push  = wr_ok && (wsub == wlast);
  assign pop   = rd_ok && (rsub == rlast);

  always_comb begin
    merged = stage;
    if (wsel == W18)     merged[woff +: 18] = wr_data[17:0];
    else if (wsel == W9) merged[woff +: 9]  = wr_data[8:0];
    else                 merged = wr_data;
  end

  always_ff @(posedge clk)
    if (push) mem[wptr] <= merged;

  always_ff @(posedge clk)
    if (!mrst_n) begin
      wptr <= '0;
      rptr <= '0;
      wsub <= '0;
      rsub <= '0;
      cnt  <= '0;
      stage <= '0;
    end else begin
      if (wr_ok) begin
        if (push) begin
          wsub <= '0;
          wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
        end else begin
          wsub  <= wsub + 1'b1;
          stage <= merged;
        end
      end
      if (rd_ok) begin
        if (pop) begin
          rsub <= '0;
          rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
        end else begin
          rsub <= rsub + 1'b1;
        end
      end
      cnt <= cnt + CW'(push) - CW'(pop);
    end

  assign head = mem[rptr];
  assign rd_data = (rsel == W18) ? {18'b0, head[roff +: 18]} :
                   (rsel == W9)  ? {27'b0, head[roff +: 9]}  : head;

  assert_mode_frozen_R3: assert property (@(posedge clk) disable iff (!mrst_n)
    1'b1 |=> ($stable(wsel) && $stable(rsel) && $stable(msb_first)));
  assert_one_side_narrow_R1: assert property (@(posedge clk) disable iff (!mrst_n)
    !(wsel != W36 && rsel != W36));
  assert_partial_not_empty_R7: assert property (@(posedge clk) disable iff (!mrst_n)
    (rsub != 2'd0) |-> !empty);
  assert_last_pop_empties_R7: assert property (@(posedge clk) disable iff (!mrst_n)
    (cnt == CW'(1) && pop && !push) |=> empty);
  assert_full_holds_R8: assert property (@(posedge clk) disable iff (!mrst_n)
    (full && !rd_en) |=> full);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!mrst_n)
    cnt <= CW'(DEPTH));
  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!mrst_n)
    !(full && empty));
endmodule

// File: tb/test_width_match_fifo.sv
`timescale 1ns/1ps
module test_width_match_fifo;
  localparam int DEPTH = 8;
  logic clk = 1'b0, mrst_n = 1'b0;
  logic cfg_mix = 0, cfg_dir = 0, cfg_fine = 0, cfg_msb_first = 0;
  logic wr_en = 0, rd_en = 0, full, empty;
  logic [35:0] wr_data = '0, rd_data;

  width_match_fifo #(.DEPTH(DEPTH)) i_width_match_fifo (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [35:0] q[$];
  logic [35:0] stage_m;
  int wn, rn, wsub_m, rsub_m;
  bit be_m;

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int subs(bit narrow, bit fine);
    if (!narrow) return 1;
    return fine ? 4 : 2;
  endfunction

  function automatic logic [35:0] lane_of(logic [35:0] w, int n, bit be, int idx);
    int pos = be ? n - 1 - idx : idx;
    if (n == 2) return {18'b0, w[pos*18 +: 18]};
    if (n == 4) return {27'b0, w[pos*9 +: 9]};
    return w;
  endfunction

  task automatic do_reset(bit m, bit d, bit f, bit be);
    cfg_mix = m; cfg_dir = d; cfg_fine = f; cfg_msb_first = be;
    wr_en = 0; rd_en = 0; mrst_n = 0;
    repeat (3) @(negedge clk);
    mrst_n = 1;
    wn = subs(m && d, f);
    rn = subs(m && !d, f);
    be_m = be;
    q.delete(); wsub_m = 0; rsub_m = 0; stage_m = '0;
    chk("R10 empty", {35'b0, empty}, 36'd1);
    chk("R10 full", {35'b0, full}, 36'd0);
  endtask

  task automatic step(bit w, logic [35:0] wd, bit r);
    bit do_w, do_r;
    int pos;
    chk("R7 empty flag", {35'b0, empty}, {35'b0, q.size() == 0});
    chk("R8 full flag", {35'b0, full}, {35'b0, q.size() == DEPTH});
    if (q.size() != 0)
      chk(rn > 1 ? (be_m ? "R4 data" : "R5 data") : (wn > 1 ? "R6 data" : "R1 data"),
          rd_data, lane_of(q[0], rn, be_m, rsub_m));
    wr_en = w; wr_data = wd; rd_en = r;
    do_w = w && q.size() != DEPTH;
    do_r = r && q.size() != 0;
    if (do_r) begin
      if (rsub_m == rn - 1) begin void'(q.pop_front()); rsub_m = 0; end
      else rsub_m++;
    end
    if (do_w) begin
      if (wn == 1) q.push_back(wd);
      else begin
        pos = be_m ? wn - 1 - wsub_m : wsub_m;
        if (wn == 2) stage_m[pos*18 +: 18] = wd[17:0];
        else         stage_m[pos*9 +: 9]   = wd[8:0];
        if (wsub_m == wn - 1) begin q.push_back(stage_m); wsub_m = 0; end
        else wsub_m++;
      end
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic rand_run(int n);
    for (int i = 0; i < n; i++)
      step(($urandom % 10) < 6, {$urandom, $urandom} , ($urandom % 10) < 5);
  endtask

  initial begin
    logic [2:0] codes [5] = '{3'b000, 3'b100, 3'b101, 3'b110, 3'b111};
    void'($urandom(32'd7));
    @(negedge clk);
    // R1 R4 R5 R6 R7 R8 R9: every pairing in both orders
    for (int c = 0; c < 5; c++)
      for (int b = 0; b < 2; b++) begin
        do_reset(codes[c][2], codes[c][1], codes[c][0], b[0]);
        rand_run(200);
      end
    // R2: unlisted code 011 acts as 36/36
    do_reset(0, 1, 1, 1);
    step(1, 36'h9_8765_4321, 0);
    chk("R2 full word", rd_data, 36'h9_8765_4321);
    // R3: pins moved after reset are ignored
    do_reset(1, 0, 1, 1);
    cfg_mix = 0; cfg_dir = 0; cfg_fine = 0; cfg_msb_first = 0;
    step(1, 36'h1_2345_6789, 0);
    chk("R3 still x9 msb first", rd_data, {27'b0, 9'h024});
    // R6: packed entry hidden until complete; R9 upper write bits dropped
    do_reset(1, 1, 1, 0);
    step(1, 36'hF_FFFF_FE11, 0);
    step(1, 36'hA_AAAA_AA22, 0);
    step(1, 36'h5_5555_5433, 0);
    chk("R6 empty before last byte", {35'b0, empty}, 36'd1);
    step(1, 36'h0_0000_0044, 0);
    chk("R6 empty after last byte", {35'b0, empty}, 36'd0);
    chk("R9 packed lanes", rd_data, {9'h044, 9'h033, 9'h022, 9'h011});
    // R7 and R9: partial read keeps not-empty, upper bits zero
    do_reset(1, 0, 1, 0);
    step(1, 36'hF_0F0F_0F0F, 0);
    chk("R9 upper zero", rd_data & ~36'h1FF, 36'd0);
    for (int k = 0; k < 3; k++) step(0, '0, 1);
    chk("R7 partial not empty", {35'b0, empty}, 36'd0);
    step(0, '0, 1);
    chk("R7 empty after last lane", {35'b0, empty}, 36'd1);
    // R8: fill past capacity, drain exactly DEPTH entries
    do_reset(0, 0, 0, 0);
    for (int k = 0; k < DEPTH + 2; k++) step(1, 36'(k + 100), 0);
    chk("R8 full", {35'b0, full}, 36'd1);
    for (int k = 0; k < DEPTH; k++) step(0, '0, 1);
    chk("R8 empty after DEPTH reads", {35'b0, empty}, 36'd1);
    step(0, '0, 1);
    chk("R8 read on empty ignored", {35'b0, empty}, 36'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule